// File: doc/BRIEF.md
# Checksum-Guarded SPI Register Target

This block is an SPI target (clock idle low, data sampled on the rising edge, changed on the falling edge) that gives a host access to a bank of 16-bit registers. Every access is one fixed frame of five bytes, most significant bit first. The frame carries a command byte, a checksum over that command, the high and low data bytes, and a checksum over the two data bytes. The command byte holds a 7-bit register address in its upper seven bits. Its lowest bit selects the direction: 1 is a read and 0 is a write. The checksum is an 8-bit CRC with generator 0x07, processed MSB first from a preset of 0x41. The data checksum starts from the preset, takes in the high byte, and then continues over the low byte.

On a read, the target checks the command checksum. It then returns the register contents in the two data byte slots, followed by a checksum it computes itself. On a write, the target commits the data only when both incoming checksums match and the write is allowed. Writes are allowed only after a key has been written to the key register at 0x08. A code written to that same register returns every register to its reset value. A fault-event register records checksum faults and command faults until the host clears them. The port registers follow a regular layout: port p (0 to NUM_PORTS-1) occupies the 16 addresses starting at (p+1)<<4. The registers are plain storage only.

The SPI pins are brought into the system clock domain through synchronizers. SCLK must therefore run well below the system clock.

Top module: `pec_spi_regs`

## Requirements
- R1: A read frame returns, in bytes 2 and 3, the last committed value of the addressed register, high byte first.
- R2: Byte 4 of a read frame is the CRC-8 (generator 0x07, MSB first) of the returned high byte, starting from the preset 0x41. The result is then continued over the returned low byte.
- R3: A write whose command checksum or data checksum does not match changes no register. It sets the checksum-fault flag, which is bit 2 of the event register at 0x02.
- R4: The fault flags in register 0x02 stay set until a write to 0x02 carries a 1 in their bit position (bit 2 for checksum faults, bit 3 for command faults). If a new fault is raised in the same cycle as the clear, the flag is set.
- R5: After reset the target is locked. While it is locked, a write to any register other than 0x08 is ignored and sets the command-fault flag (bit 3 of 0x02).
- R6: Writing 0x05 in the low byte of 0x08 unlocks the target, and 0x08 then reads 0x0005. Writing 0xA0 locks it, and 0x08 then reads 0x00A0. Any other low-byte value except the reset code is ignored and sets the command-fault flag.
- R7: Writing 0x73 in the low byte of 0x08 returns every register to its reset value and leaves the target locked.
- R8: For port p below NUM_PORTS, the registers at ((p+1)<<4)+k with k in {0,2,3,4,5,6,7} are read/write storage. Global storage sits at 0x03, 0x09, 0x0A and 0x0B. Any other address, except 0x02, 0x06 and 0x08, is unmapped: a read of it returns 0, and any access to it sets the command-fault flag.
- R9: Register 0x06 reads NUM_PORTS in bits 4:0, with zeros above. Writes to it have no effect.
- R10: If chip select is released before all 40 bits of a frame have arrived, the frame commits nothing and raises no fault.
- R11: A read whose command checksum does not match returns zero data with the checksum of zero data, and sets the checksum-fault flag.
- R12: MISO is low while chip select is high and during the first two bytes of every frame. After reset, all storage, the event register and the key register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, driven low outside read data |

## Verification
The assertions assume a well-formed SPI stream. SCLK must be low whenever chip select changes. Each SCLK level must last several system clocks, so that every edge is seen once and MOSI is stable around each rising edge once it has passed the synchronizers. The bench drives all SPI pins on the falling edge of the system clock, holds each SCLK level for six system clocks, and moves chip select only while SCLK is low. Truncated frames are produced only by releasing chip select between bits, never in the middle of an SCLK pulse.

// File: rtl/pec_spi_pkg.sv
package pec_spi_pkg;

  localparam int          FRAME_BITS = 40;
  localparam logic [7:0]  PEC_SEED   = 8'h41;
  localparam logic [7:0]  PEC_POLY   = 8'h07;
  localparam logic [7:0]  KEY_OPEN   = 8'h05;
  localparam logic [7:0]  KEY_CLOSE  = 8'hA0;
  localparam logic [7:0]  CODE_SRST  = 8'h73;
  localparam logic [6:0]  ADDR_EVT   = 7'h02;
  localparam logic [6:0]  ADDR_CAP   = 7'h06;
  localparam logic [6:0]  ADDR_KEY   = 7'h08;
  localparam int          EVT_PEC    = 2;
  localparam int          EVT_CMD    = 3;

  // bit-serial CRC-8 step over one byte, MSB first
  function automatic logic [7:0] pec8_byte(input logic [7:0] crc_in, input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ PEC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/pec_spi_frontend.sv
module pec_spi_frontend (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic cs_act,
  output logic rise,
  output logic fall,
  output logic mosi_bit
);
  logic [2:0] sclk_s;
  logic [1:0] cs_s;
  logic [1:0] mosi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= 2'b11;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  assign cs_act   = ~cs_s[1];
  assign rise     = sclk_s[1] & ~sclk_s[2];
  assign fall     = ~sclk_s[1] & sclk_s[2];
  assign mosi_bit = mosi_s[1];
endmodule

// File: rtl/pec_frame_ctrl.sv
module pec_frame_ctrl
  import pec_spi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_act,
  input  logic        rise,
  input  logic        fall,
  input  logic        mosi_bit,
  input  logic [15:0] rd_data,
  input  logic        rd_mapped,
  input  logic        wr_reject,
  output logic [6:0]  reg_addr,
  output logic [15:0] wr_data,
  output logic        wr_en,
  output logic        set_pec,
  output logic        set_cmd,
  output logic        miso,
  output logic [5:0]  bit_cnt
);
  localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS);
  localparam logic [5:0] TX_FIRST = 6'd16;
  localparam logic [5:0] TX_LAST  = 6'(FRAME_BITS - 1);

  logic [5:0]  cnt_q, cnt_d;
  logic [7:0]  sh_q, sh_d, cmd_q, cmd_d, dhi_q, dhi_d, dlo_q, dlo_d;
  logic        cok_q, cok_d;
  logic [23:0] tx_q, tx_d;
  logic        miso_q, miso_d;

  logic [7:0]  sh_in;
  logic        take, byte_done, tx_window;
  logic [5:0]  tx_pos;
  logic        cmd_ok_now, data_ok_now, wr_good;
  logic [15:0] rd_word;
  logic [7:0]  rd_pec;

  always_comb begin
    sh_in       = {sh_q[6:0], mosi_bit};
    take        = cs_act && rise && (cnt_q < LAST_BIT);
    byte_done   = take && (cnt_q[2:0] == 3'd7);
    tx_window   = (cnt_q >= TX_FIRST) && (cnt_q <= TX_LAST);
    tx_pos      = TX_LAST - cnt_q;
    cmd_ok_now  = (sh_in == pec8_byte(PEC_SEED, cmd_q));
    data_ok_now = (sh_in == pec8_byte(pec8_byte(PEC_SEED, dhi_q), dlo_q));
    wr_good     = cok_q && data_ok_now;
    rd_word     = (cmd_ok_now && rd_mapped) ? rd_data : 16'h0000;
    rd_pec      = pec8_byte(pec8_byte(PEC_SEED, rd_word[15:8]), rd_word[7:0]);
  end

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    cmd_d   = cmd_q;
    dhi_d   = dhi_q;
    dlo_d   = dlo_q;
    cok_d   = cok_q;
    tx_d    = tx_q;
    miso_d  = miso_q;
    wr_en   = 1'b0;
    set_pec = 1'b0;
    set_cmd = 1'b0;
    if (!cs_act) begin
      cnt_d  = '0;
      tx_d   = '0;
      miso_d = 1'b0;
    end else begin
      if (fall) miso_d = tx_window ? tx_q[tx_pos[4:0]] : 1'b0;
      if (take) begin
        cnt_d = cnt_q + 6'd1;
        sh_d  = sh_in;
      end
      if (byte_done) begin
        case (cnt_q[5:3])
          3'd0: cmd_d = sh_in;
          3'd1: begin
            cok_d = cmd_ok_now;
            if (cmd_q[0]) begin
              tx_d    = {rd_word, rd_pec};
              set_pec = !cmd_ok_now;
              set_cmd = cmd_ok_now && !rd_mapped;
            end
          end
          3'd2: dhi_d = sh_in;
          3'd3: dlo_d = sh_in;
          3'd4: begin
            if (!cmd_q[0]) begin
              wr_en   = wr_good && !wr_reject;
              set_pec = !wr_good;
              set_cmd = wr_good && wr_reject;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      cmd_q  <= '0;
      dhi_q  <= '0;
      dlo_q  <= '0;
      cok_q  <= 1'b0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      cmd_q  <= cmd_d;
      dhi_q  <= dhi_d;
      dlo_q  <= dlo_d;
      cok_q  <= cok_d;
      tx_q   <= tx_d;
      miso_q <= miso_d;
    end
  end

  assign reg_addr = cmd_q[7:1];
  assign wr_data  = {dhi_q, dlo_q};
  assign miso     = miso_q;
  assign bit_cnt  = cnt_q;
endmodule

// File: rtl/pec_reg_bank.sv
module pec_reg_bank
  import pec_spi_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  addr,
  input  logic [15:0] wr_data,
  input  logic        wr_en,
  input  logic        set_pec,
  input  logic        set_cmd,
  output logic [15:0] rd_data,
  output logic        rd_mapped,
  output logic        wr_reject,
  output logic        locked,
  output logic [1:0]  evt_bits,
  output logic        srst
);
  localparam logic [7:0]  PORT_OFS_MAP  = 8'b1111_1101;
  localparam logic [15:0] GLB_STORE_MAP = 16'h0E08;
  localparam int          SLOT_SPAN     = 64;
  localparam int          GLB_SPAN      = 16;

  logic [7:0]  key_q, key_d;
  logic [1:0]  evt_q, evt_d;
  logic [15:0] pval [SLOT_SPAN];
  logic [15:0] gval [GLB_SPAN];

  logic [2:0]  pfield;
  logic [5:0]  slot;
  logic        in_port, in_glb, glb_store, key_hit, key_code_ok;

  always_comb begin
    pfield      = addr[6:4];
    slot        = {pfield - 3'd1, addr[2:0]};
    glb_store   = GLB_STORE_MAP[addr[3:0]];
    in_port     = (pfield != 3'd0) && (pfield <= 3'(NUM_PORTS)) && !addr[3] &&
                  PORT_OFS_MAP[addr[2:0]];
    in_glb      = (pfield == 3'd0) &&
                  (glb_store || addr == ADDR_EVT || addr == ADDR_CAP || addr == ADDR_KEY);
    rd_mapped   = in_port || in_glb;
    key_hit     = (addr == ADDR_KEY);
    key_code_ok = (wr_data[7:0] == KEY_OPEN) || (wr_data[7:0] == KEY_CLOSE) ||
                  (wr_data[7:0] == CODE_SRST);
    locked      = (key_q != KEY_OPEN);
    srst        = wr_en && key_hit && (wr_data[7:0] == CODE_SRST);
    if (key_hit)         wr_reject = !key_code_ok;
    else if (!rd_mapped) wr_reject = 1'b1;
    else                 wr_reject = locked;
  end

  always_comb begin
    rd_data = 16'h0000;
    if (in_port) rd_data = pval[slot];
    else if (in_glb) begin
      case (addr)
        ADDR_EVT: rd_data = {12'h000, evt_q, 2'b00};
        ADDR_CAP: rd_data = 16'(NUM_PORTS);
        ADDR_KEY: rd_data = {8'h00, key_q};
        default:  rd_data = gval[addr[3:0]];
      endcase
    end
  end

  always_comb begin
    key_d = key_q;
    evt_d = evt_q;
    if (srst) begin
      key_d = 8'h00;
      evt_d = 2'b00;
    end else begin
      if (wr_en && key_hit) key_d = wr_data[7:0];
      if (wr_en && addr == ADDR_EVT) evt_d = evt_q & ~{wr_data[EVT_CMD], wr_data[EVT_PEC]};
      evt_d = evt_d | {set_cmd, set_pec};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= 8'h00;
      evt_q <= 2'b00;
    end else begin
      key_q <= key_d;
      evt_q <= evt_d;
    end
  end

  for (genvar s = 0; s < SLOT_SPAN; s++) begin : g_slot
    if ((s / 8) < NUM_PORTS && PORT_OFS_MAP[s % 8]) begin : g_reg
      logic [15:0] q, d;
      always_comb begin
        d = q;
        if (srst) d = '0;
        else if (wr_en && in_port && slot == 6'(s)) d = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign pval[s] = q;
    end else begin : g_none
      assign pval[s] = '0;
    end
  end

  for (genvar g = 0; g < GLB_SPAN; g++) begin : g_glb
    if (GLB_STORE_MAP[g]) begin : g_reg
      logic [15:0] q, d;
      always_comb begin
        d = q;
        if (srst) d = '0;
        else if (wr_en && in_glb && addr[3:0] == 4'(g)) d = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign gval[g] = q;
    end else begin : g_none
      assign gval[g] = '0;
    end
  end

  assign evt_bits = evt_q;
endmodule

// File: rtl/pec_spi_regs.sv
module pec_spi_regs #(
  parameter int NUM_PORTS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic [1:0]  rst_pipe;
  logic        rst_sn;
  logic        cs_act, rise, fall, mosi_bit;
  logic [6:0]  reg_addr;
  logic [15:0] wr_data, rd_data;
  logic        wr_en, set_pec, set_cmd, rd_mapped, wr_reject;
  logic        locked, srst;
  logic [1:0]  evt_bits;
  logic [5:0]  bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  pec_spi_frontend u_front (
    .clk      (clk),
    .rst_n    (rst_sn),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .cs_act   (cs_act),
    .rise     (rise),
    .fall     (fall),
    .mosi_bit (mosi_bit)
  );

  pec_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cs_act    (cs_act),
    .rise      (rise),
    .fall      (fall),
    .mosi_bit  (mosi_bit),
    .rd_data   (rd_data),
    .rd_mapped (rd_mapped),
    .wr_reject (wr_reject),
    .reg_addr  (reg_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .set_pec   (set_pec),
    .set_cmd   (set_cmd),
    .miso      (spi_miso),
    .bit_cnt   (bit_cnt)
  );

  pec_reg_bank #(.NUM_PORTS(NUM_PORTS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sn),
    .addr      (reg_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .set_pec   (set_pec),
    .set_cmd   (set_cmd),
    .rd_data   (rd_data),
    .rd_mapped (rd_mapped),
    .wr_reject (wr_reject),
    .locked    (locked),
    .evt_bits  (evt_bits),
    .srst      (srst)
  );
endmodule

// File: rtl/pec_spi_regs_chk.sv
module pec_spi_regs_chk
  import pec_spi_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_act,
  input logic [5:0]  bit_cnt,
  input logic        wr_en,
  input logic [6:0]  reg_addr,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        set_pec,
  input logic        srst,
  input logic        locked,
  input logic [1:0]  evt_bits
);
  // R3
  pec_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_bits[0]) |-> $past(set_pec));

  // R4
  pec_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_bits[0]) |->
      ($past(wr_en && reg_addr == ADDR_EVT && wr_data[EVT_PEC]) || $past(srst)));

  // R6
  lock_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked) |-> $past(wr_en && reg_addr == ADDR_KEY));

  // R9
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CAP) |-> (rd_data == 16'(NUM_PORTS)));

  // R10
  full_frame_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cs_act && bit_cnt == 6'(FRAME_BITS - 1)));
endmodule

bind pec_spi_regs pec_spi_regs_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_act   (cs_act),
  .bit_cnt  (bit_cnt),
  .wr_en    (wr_en),
  .reg_addr (reg_addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .set_pec  (set_pec),
  .srst     (srst),
  .locked   (locked),
  .evt_bits (evt_bits)
);

// File: tb/tb_pec_spi_regs.sv
module tb_pec_spi_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  wire  miso;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] model [128];
  logic [7:0]  m_key;
  logic [1:0]  m_evt;   // [0] checksum fault, [1] command fault
  logic [6:0]  store_list [64];
  int          n_store = 0;

  pec_spi_regs dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] crc_ref(input logic [7:0] seed, input logic [7:0] b);
    logic [7:0] c;
    c = seed ^ b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  function automatic bit is_store(input logic [6:0] a);
    if (a[6:4] == 3'd0) return (a[3:0] == 4'h3) || (a[3:0] == 4'h9) ||
                               (a[3:0] == 4'hA) || (a[3:0] == 4'hB);
    return (a[6:4] <= 3'd5) && !a[3] && (a[2:0] != 3'd1);
  endfunction

  function automatic bit is_mapped(input logic [6:0] a);
    return is_store(a) || a == 7'h02 || a == 7'h06 || a == 7'h08;
  endfunction

  function automatic logic [15:0] exp_val(input logic [6:0] a);
    if (a == 7'h02) return {12'h000, m_evt, 2'b00};
    if (a == 7'h06) return 16'd5;
    if (a == 7'h08) return {8'h00, m_key};
    if (is_store(a)) return model[a];
    return 16'h0000;
  endfunction

  function automatic logic [39:0] mk_frame(input logic [6:0] a, input bit rd,
                                           input logic [15:0] d, input bit bad_c, input bit bad_d);
    logic [7:0] cmd, cp, dp;
    cmd = {a, rd};
    cp  = crc_ref(8'h41, cmd) ^ (bad_c ? 8'hFF : 8'h00);
    dp  = crc_ref(crc_ref(8'h41, d[15:8]), d[7:0]) ^ (bad_d ? 8'h5A : 8'h00);
    return {cmd, cp, d, dp};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 128; i++) model[i] = 16'h0000;
    m_key = 8'h00;
    m_evt = 2'b00;
  endtask

  task automatic run_frame(input logic [39:0] tx, input int nbits, output logic [39:0] rx);
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      mosi = tx[39 - k];
      repeat (HALF) @(negedge clk);
      rx[39 - k] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d, input bit bad_c, input bit bad_d);
    logic [39:0] rx;
    run_frame(mk_frame(a, 1'b0, d, bad_c, bad_d), 40, rx);
    if (bad_c || bad_d) m_evt[0] = 1'b1;
    else if (a == 7'h08) begin
      if (d[7:0] == 8'h73) model_reset();
      else if (d[7:0] == 8'h05 || d[7:0] == 8'hA0) m_key = d[7:0];
      else m_evt[1] = 1'b1;
    end else if (!is_mapped(a) || m_key != 8'h05) m_evt[1] = 1'b1;
    else if (a == 7'h02) m_evt = m_evt & ~{d[3], d[2]};
    else if (is_store(a)) model[a] = d;
  endtask

  task automatic rd_chk(input logic [6:0] a, input bit bad_c, input string tag);
    logic [39:0] rx;
    logic [15:0] e;
    logic [7:0]  ep;
    run_frame(mk_frame(a, 1'b1, 16'h0000, bad_c, 1'b0), 40, rx);
    e  = bad_c ? 16'h0000 : exp_val(a);
    ep = crc_ref(crc_ref(8'h41, e[15:8]), e[7:0]);
    check(rx[23:8] == e, tag, 32'(rx[23:8]), 32'(e));
    // R2 returned checksum
    check(rx[7:0] == ep, "R2 read checksum", 32'(rx[7:0]), 32'(ep));
    // R12 quiet during command bytes
    check(rx[39:24] == 16'h0000, "R12 miso in command bytes", 32'(rx[39:24]), 0);
    if (bad_c) m_evt[0] = 1'b1;
    else if (!is_mapped(a)) m_evt[1] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] rx;
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    model_reset();
    for (int i = 0; i < 128; i++) if (is_store(7'(i))) begin
      store_list[n_store] = 7'(i);
      n_store++;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(miso == 1'b0, "R12 reset miso", 32'(miso), 0);

    // reset state and capability
    rd_chk(7'h06, 1'b0, "R9 capability");
    rd_chk(7'h02, 1'b0, "R12 reset event register");
    rd_chk(7'h08, 1'b0, "R12 reset key register");
    rd_chk(7'h13, 1'b0, "R12 reset storage");

    // locked write
    wr(7'h13, 16'hBEEF, 1'b0, 1'b0);
    rd_chk(7'h13, 1'b0, "R5 locked write ignored");
    rd_chk(7'h02, 1'b0, "R5 command fault flag");

    // unlock and clear
    wr(7'h08, 16'h0005, 1'b0, 1'b0);
    rd_chk(7'h08, 1'b0, "R6 unlock readback");
    wr(7'h02, 16'h000C, 1'b0, 1'b0);
    rd_chk(7'h02, 1'b0, "R4 clear by writing ones");

    // checksum faults on writes
    wr(7'h14, 16'h1234, 1'b0, 1'b0);
    wr(7'h14, 16'h5555, 1'b1, 1'b0);
    rd_chk(7'h14, 1'b0, "R3 bad command checksum discarded");
    wr(7'h14, 16'h6666, 1'b0, 1'b1);
    rd_chk(7'h14, 1'b0, "R3 bad data checksum discarded");
    rd_chk(7'h02, 1'b0, "R3 checksum fault flag");
    wr(7'h02, 16'h0008, 1'b0, 1'b0);
    rd_chk(7'h02, 1'b0, "R4 other flag stays");
    wr(7'h02, 16'h0004, 1'b0, 1'b0);
    rd_chk(7'h02, 1'b0, "R4 flag cleared");

    // bad read command checksum
    rd_chk(7'h14, 1'b1, "R11 bad read checksum zero data");
    rd_chk(7'h02, 1'b0, "R11 checksum fault flag");
    wr(7'h02, 16'h000C, 1'b0, 1'b0);

    // address map sweep
    for (int i = 0; i < n_store; i++) wr(store_list[i], 16'hA000 ^ {9'h0, store_list[i]}, 1'b0, 1'b0);
    for (int i = 0; i < n_store; i++) rd_chk(store_list[i], 1'b0, "R8 mapped storage");
    rd_chk(7'h11, 1'b0, "R8 unmapped offset one");
    rd_chk(7'h02, 1'b0, "R8 unmapped read fault");
    wr(7'h02, 16'h000C, 1'b0, 1'b0);
    wr(7'h60, 16'h7777, 1'b0, 1'b0);
    rd_chk(7'h60, 1'b0, "R8 port beyond count");
    rd_chk(7'h18, 1'b0, "R8 unmapped high offset");
    rd_chk(7'h02, 1'b0, "R8 unmapped write fault");
    wr(7'h02, 16'h000C, 1'b0, 1'b0);
    wr(7'h06, 16'h00FF, 1'b0, 1'b0);
    rd_chk(7'h06, 1'b0, "R9 capability write ignored");

    // truncated frames
    run_frame(mk_frame(7'h25, 1'b0, 16'hDEAD, 1'b0, 1'b0), 20, rx);
    run_frame(mk_frame(7'h25, 1'b0, 16'hDEAD, 1'b0, 1'b0), 39, rx);
    rd_chk(7'h25, 1'b0, "R10 truncated frame no commit");
    rd_chk(7'h02, 1'b0, "R10 truncated frame no fault");

    // random mix
    for (int n = 0; n < 50; n++) begin
      int r;
      logic [6:0] a;
      r = int'($urandom % 10);
      a = store_list[$urandom % n_store];
      if (r < 5) wr(a, 16'($urandom), 1'b0, 1'b0);
      else if (r < 8) rd_chk(a, 1'b0, "R1 random readback");
      else if (r == 8) wr(a, 16'($urandom), 1'($urandom), 1'b1);
      else rd_chk(7'($urandom), 1'b0, "R8 random address");
    end
    rd_chk(7'h02, 1'b0, "R4 flags after random mix");
    wr(7'h02, 16'h000C, 1'b0, 1'b0);

    // relock, invalid key, unlock
    wr(7'h08, 16'h00A0, 1'b0, 1'b0);
    rd_chk(7'h08, 1'b0, "R6 lock readback");
    wr(7'h25, 16'h0BAD, 1'b0, 1'b0);
    rd_chk(7'h25, 1'b0, "R5 relocked write ignored");
    wr(7'h08, 16'h0042, 1'b0, 1'b0);
    rd_chk(7'h08, 1'b0, "R6 invalid key ignored");
    rd_chk(7'h02, 1'b0, "R6 invalid key fault");
    wr(7'h08, 16'hFF05, 1'b0, 1'b0);
    rd_chk(7'h08, 1'b0, "R6 unlock by low byte");

    // soft reset
    wr(7'h33, 16'hC0DE, 1'b0, 1'b0);
    wr(7'h08, 16'h0073, 1'b0, 1'b0);
    rd_chk(7'h33, 1'b0, "R7 soft reset storage");
    rd_chk(7'h09, 1'b0, "R7 soft reset global");
    rd_chk(7'h08, 1'b0, "R7 soft reset locks");
    wr(7'h33, 16'h1111, 1'b0, 1'b0);
    rd_chk(7'h33, 1'b0, "R7 locked after soft reset");

    check(miso == 1'b0, "R12 idle miso", 32'(miso), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule